// File: doc/BRIEF.md
# Tree-Structured Chip-Select Decoder

This block turns a 24-bit byte address and an active-low address strobe into twenty active-low chip selects: four for ROM blocks, eight for RAM blocks and eight for peripherals. It is combinational. The selects are built from a tree of 3-to-8 decoders. Each decoder has one active-high enable and two active-low enables, so the output of one stage can enable the next.

The root stage splits the low 512 KB of the space into 64 KB segments. It is enabled by a NOR of the top five address bits. Segment 0 feeds the ROM decoder, segment 2 feeds the RAM decoder, and segment 1 feeds an extra page stage that picks the first 128 bytes for the peripheral decoder. The strobe enters only the three leaf decoders. The upper stages can therefore settle while the address is still valid and the strobe is high.

Within each bus, bit i drives the block at the i-th lowest address.

Top module: `csel_tree`

## Requirements
- R1: `rom_sel_n[n]` (n = 0..3) is low exactly when `strobe_n` is low and the address lies in 0x000000 + n*0x2000 through 0x001FFF + n*0x2000.
- R2: `ram_sel_n[k]` (k = 0..7) is low exactly when `strobe_n` is low and the address lies in 0x020000 + k*0x800 through 0x0207FF + k*0x800.
- R3: `per_sel_n[j]` (j = 0..7) is low exactly when `strobe_n` is low and the address lies in 0x010000 + j*0x10 through 0x01000F + j*0x10.
- R4: While `strobe_n` is high, all twenty selects are high, whatever the address.
- R5: At most one of the twenty selects is low at any time.
- R6: No select is low for an address outside the three regions. This includes the neighbours 0x008000, 0x010080, 0x00FFFF, 0x024000, 0x01FFFF and any address with a bit among 23..19 set.
- R7: A leaf select is low only while its tree stage above it (its 64 KB segment, and for peripherals also the 128-byte page) is selected by the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 24 | Byte address |
| strobe_n | input | 1 | Active-low address strobe, gates the leaf stage |
| rom_sel_n | output | 4 | Active-low ROM block selects, 8 KB each |
| ram_sel_n | output | 8 | Active-low RAM block selects, 2 KB each |
| per_sel_n | output | 8 | Active-low peripheral selects, 16 bytes each |

## Verification
On every input change the assertions check these properties:
- the selects are mutually exclusive;
- all selects are quiet while the strobe is high;
- every active select has an address inside its own region;
- every active select has its intermediate tree stage enabled.

These checks cannot show that the right index is chosen, or that an in-range address actually produces a select. Only the bench scenarios show those. The bench applies both edges of every block, the addresses just beyond each region and randomized addresses, and compares all twenty selects against a range-based model.

// File: rtl/csel_tree_pkg.sv
package csel_tree_pkg;
  localparam int ADDR_W   = 24;
  localparam int CODE_W   = 3;
  localparam int FAN      = 1 << CODE_W;
  localparam int ROM_CNT  = 4;
  localparam int RAM_CNT  = 8;
  localparam int PER_CNT  = 8;
  // bit positions of the decoded fields
  localparam int SEG_LSB  = 16;  // 64 KB segment code
  localparam int TOP_LSB  = SEG_LSB + CODE_W;  // bits above root must be zero
  localparam int ROM_LSB  = 13;  // 8 KB ROM blocks
  localparam int RAM_LSB  = 11;  // 2 KB RAM blocks
  localparam int PPG_LSB  = 7;   // 128-byte peripheral page
  localparam int PER_LSB  = 4;   // 16-byte peripheral slots
  // segment codes seen at the root
  localparam int SEG_ROM  = 0;
  localparam int SEG_PER  = 1;
  localparam int SEG_RAM  = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t field3(input addr_t a, input int lsb);
    return a[lsb +: CODE_W];
  endfunction

  // true when every bit in [hi:lo] of a is zero
  function automatic logic span_zero(input addr_t a, input int hi, input int lo);
    logic z;
    z = 1'b1;
    for (int b = 0; b < ADDR_W; b++)
      if (b >= lo && b <= hi && a[b]) z = 1'b0;
    return z;
  endfunction
endpackage

// File: rtl/csel_dec3to8.sv
module csel_dec3to8 #(
  parameter int OUTS = 8
) (
  input  logic [2:0]      code,
  input  logic            en_hi,
  input  logic            en_lo_a_n,
  input  logic            en_lo_b_n,
  output logic [OUTS-1:0] out_n
);
  logic enabled;
  assign enabled = en_hi & ~en_lo_a_n & ~en_lo_b_n;

  for (genvar i = 0; i < OUTS; i++) begin : g_out
    assign out_n[i] = ~(enabled && (code == 3'(i)));
  end
endmodule

// File: rtl/csel_tree.sv
module csel_tree
  import csel_tree_pkg::*;
(
  input  logic [23:0] addr,
  input  logic        strobe_n,
  output logic [3:0]  rom_sel_n,
  output logic [7:0]  ram_sel_n,
  output logic [7:0]  per_sel_n
);
  localparam int ROOT_OUTS = SEG_RAM + 1;

  // qualifying terms (NOR-style gates instead of extra decoder stages)
  logic top_zero;      // bits 23..19 all zero
  logic ram_gap_zero;  // bits 15..14 zero inside RAM segment
  logic per_gap_zero;  // bits 15..10 zero inside peripheral segment
  logic rom_top_zero;  // bit 15 zero inside ROM segment

  assign top_zero     = span_zero(addr, ADDR_W-1, TOP_LSB);
  assign ram_gap_zero = span_zero(addr, SEG_LSB-1, RAM_LSB+CODE_W);
  assign per_gap_zero = span_zero(addr, SEG_LSB-1, PPG_LSB+CODE_W);
  assign rom_top_zero = span_zero(addr, SEG_LSB-1, ROM_LSB+2);

  // root stage: 64 KB segments
  logic [ROOT_OUTS-1:0] seg_n;
  csel_dec3to8 #(.OUTS(ROOT_OUTS)) u_root (
    .code      (field3(addr, SEG_LSB)),
    .en_hi     (top_zero),
    .en_lo_a_n (1'b0),
    .en_lo_b_n (1'b0),
    .out_n     (seg_n)
  );

  // named stage wires (observed by the checker)
  logic seg_rom_n, seg_per_n, seg_ram_n, page_per_n;
  assign seg_rom_n = seg_n[SEG_ROM];
  assign seg_per_n = seg_n[SEG_PER];
  assign seg_ram_n = seg_n[SEG_RAM];

  // middle stage: first 128-byte page of the peripheral segment
  logic [0:0] ppg_n;
  csel_dec3to8 #(.OUTS(1)) u_per_page (
    .code      (field3(addr, PPG_LSB)),
    .en_hi     (per_gap_zero),
    .en_lo_a_n (seg_per_n),
    .en_lo_b_n (1'b0),
    .out_n     (ppg_n)
  );
  assign page_per_n = ppg_n[0];

  // leaf stage: the strobe enters only here
  csel_dec3to8 #(.OUTS(ROM_CNT)) u_rom_leaf (
    .code      (field3(addr, ROM_LSB)),
    .en_hi     (rom_top_zero),
    .en_lo_a_n (seg_rom_n),
    .en_lo_b_n (strobe_n),
    .out_n     (rom_sel_n)
  );

  csel_dec3to8 #(.OUTS(RAM_CNT)) u_ram_leaf (
    .code      (field3(addr, RAM_LSB)),
    .en_hi     (ram_gap_zero),
    .en_lo_a_n (seg_ram_n),
    .en_lo_b_n (strobe_n),
    .out_n     (ram_sel_n)
  );

  csel_dec3to8 #(.OUTS(PER_CNT)) u_per_leaf (
    .code      (field3(addr, PER_LSB)),
    .en_hi     (1'b1),
    .en_lo_a_n (page_per_n),
    .en_lo_b_n (strobe_n),
    .out_n     (per_sel_n)
  );

  // word offset bits go to the selected device, not the decoder
  logic unused_offset;
  assign unused_offset = ^addr[PER_LSB-1:0];
endmodule

// File: rtl/csel_tree_chk.sv
module csel_tree_chk (
  input logic [23:0] addr,
  input logic        strobe_n,
  input logic [3:0]  rom_sel_n,
  input logic [7:0]  ram_sel_n,
  input logic [7:0]  per_sel_n,
  input logic        seg_rom_n,
  input logic        seg_ram_n,
  input logic        page_per_n
);
  logic [19:0] act;
  assign act = ~{per_sel_n, ram_sel_n, rom_sel_n};

  always_comb begin
    p_excl_r5: assert ($onehot0(act)) else $error("R5 more than one select");
    p_strobe_gate_r4: assert (!(strobe_n && act != 20'd0)) else $error("R4 select with strobe high");
    p_rom_range_r1: assert (!((~rom_sel_n) != 4'd0 && addr >= 24'h008000))
      else $error("R1 ROM select out of range");
    p_ram_range_r2: assert (!((~ram_sel_n) != 8'd0 && (addr < 24'h020000 || addr > 24'h023FFF)))
      else $error("R2 RAM select out of range");
    p_per_range_r3: assert (!((~per_sel_n) != 8'd0 && (addr < 24'h010000 || addr > 24'h01007F)))
      else $error("R3 peripheral select out of range");
    p_rom_chain_r7: assert (!((~rom_sel_n) != 4'd0 && seg_rom_n)) else $error("R7 ROM stage");
    p_ram_chain_r7: assert (!((~ram_sel_n) != 8'd0 && seg_ram_n)) else $error("R7 RAM stage");
    p_per_chain_r7: assert (!((~per_sel_n) != 8'd0 && page_per_n)) else $error("R7 peripheral stage");
  end
endmodule

bind csel_tree csel_tree_chk u_chk (
  .addr       (addr),
  .strobe_n   (strobe_n),
  .rom_sel_n  (rom_sel_n),
  .ram_sel_n  (ram_sel_n),
  .per_sel_n  (per_sel_n),
  .seg_rom_n  (seg_rom_n),
  .seg_ram_n  (seg_ram_n),
  .page_per_n (page_per_n)
);

// File: tb/csel_tree_test.sv
module csel_tree_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [23:0] addr = '0;
  logic        strobe_n = 1'b1;
  logic [3:0]  rom_sel_n;
  logic [7:0]  ram_sel_n;
  logic [7:0]  per_sel_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  csel_tree uut (
    .addr(addr), .strobe_n(strobe_n),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n), .per_sel_n(per_sel_n)
  );

  // expected active-low vector {per, ram, rom} from the address ranges
  function automatic logic [19:0] model(input logic [23:0] a, input logic s_n);
    logic [19:0] v;
    v = '1;
    if (!s_n) begin
      for (int n = 0; n < 4; n++)
        if (a >= 24'(n * 'h2000) && a <= 24'(n * 'h2000 + 'h1FFF)) v[n] = 1'b0;
      for (int k = 0; k < 8; k++)
        if (a >= 24'('h20000 + k * 'h800) && a <= 24'('h207FF + k * 'h800)) v[4 + k] = 1'b0;
      for (int j = 0; j < 8; j++)
        if (a >= 24'('h10000 + j * 'h10) && a <= 24'('h1000F + j * 'h10)) v[12 + j] = 1'b0;
    end
    return v;
  endfunction

  task automatic apply(input logic [23:0] a, input logic s_n, input string req);
    logic [19:0] got, exp;
    @(posedge clk);
    addr <= a;
    strobe_n <= s_n;
    @(negedge clk);
    got = {per_sel_n, ram_sel_n, rom_sel_n};
    exp = model(a, s_n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%06h strobe_n=%0b got=%05h exp=%05h", req, a, s_n, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    int sd;
    sd = $urandom(32'h5EED);
    // reset-like state: strobe high
    apply(24'h000000, 1'b1, "R4");
    apply(24'h020000, 1'b1, "R4");
    apply(24'h010000, 1'b1, "R4");
    // R1 ROM edges
    for (int n = 0; n < 4; n++) begin
      apply(24'(n * 'h2000), 1'b0, "R1");
      apply(24'(n * 'h2000 + 'h1FFF), 1'b0, "R1");
    end
    // R2 RAM edges
    for (int k = 0; k < 8; k++) begin
      apply(24'('h20000 + k * 'h800), 1'b0, "R2");
      apply(24'('h207FF + k * 'h800), 1'b0, "R2");
    end
    // R3 peripheral edges
    for (int j = 0; j < 8; j++) begin
      apply(24'('h10000 + j * 'h10), 1'b0, "R3");
      apply(24'('h1000F + j * 'h10), 1'b0, "R3");
    end
    // R6 neighbours outside all regions
    apply(24'h008000, 1'b0, "R6");
    apply(24'h00FFFF, 1'b0, "R6");
    apply(24'h010080, 1'b0, "R6");
    apply(24'h010400, 1'b0, "R6");
    apply(24'h01FFFF, 1'b0, "R6");
    apply(24'h024000, 1'b0, "R6");
    apply(24'h030000, 1'b0, "R6");
    apply(24'h080000, 1'b0, "R6");
    apply(24'h800000, 1'b0, "R6");
    apply(24'h420000, 1'b0, "R6");
    // randomized, biased toward the regions (R5, R7 covered by the same checks)
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 4))
        0: a = 24'($urandom_range(0, 'h9FFF));
        1: a = 24'($urandom_range('h1FF00, 'h24100));
        2: a = 24'($urandom_range('hFFF0, 'h100A0));
        3: a = 24'($urandom) & 24'h0FFFFF;
        default: a = 24'($urandom);
      endcase
      apply(a, 1'($urandom_range(0, 3) == 0), "R5");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule